// File: doc/BRIEF.md
# Priority-Grouped Free Channel Allocator

This block hands out physical DMA channels from a pool of up to 32. It holds a busy bitmap with one bit per channel. When a requester raises an allocate request, the block looks for a free channel and returns its index in the same cycle, together with a grant flag. If every channel is taken, it raises a none-free flag instead. The bitmap bit of the granted channel is set at the next clock edge. A separate release port names a channel index, and that channel's bit is cleared at the same edge, so the channel can be granted again.

The search follows fixed priority groups. Bits 3:2 of a channel index give its level, and level 0 ranks highest. So channels 0-3 and 16-19 share level 0, 4-7 and 20-23 share level 1, 8-11 and 24-27 share level 2, and 12-15 and 28-31 share level 3. The block checks every channel of one level, lowest index first, before it moves to the next level. The release in a cycle is applied before the search, so a channel freed in a cycle can be granted in that same cycle. Tracking which requester owns which channel, and programming the granted channel, are left to the logic around the block.

Top module: `prio_chan_alloc`

## Requirements
- R1: While reset is asserted and after it is released, the busy bitmap is all zero and no grant or none-free flag is raised while no allocate request is present.
- R2: The level of channel i is (i mod 16) >> 2, that is bits 3:2 of its index, and level 0 is the highest priority.
- R3: An allocate request grants the free channel in the lowest-numbered level that has one, and within that level the lowest free index, so a full fill of 32 channels returns 0,1,2,3,16,17,18,19,4,5,6,7,20,... in order.
- R4: A grant drives alloc_gnt high and alloc_idx to the chosen index in the cycle of the request, and the bitmap bit of that index reads 1 after the next clock edge.
- R5: When no channel is free, an allocate request raises alloc_none, keeps alloc_gnt low and leaves the bitmap unchanged.
- R6: A release request of a busy channel below NUM_CH clears its bitmap bit at the next clock edge.
- R7: Channels at or above NUM_CH never appear in a grant and have no bitmap bit. Once channels 0 to NUM_CH-1 are all busy, the result is none-free.
- R8: When a release and an allocate occur in the same cycle, the release is applied first. The released channel takes part in that cycle's search, and if it is granted its bit stays 1.
- R9: Releasing a channel that is already free, or an index at or above NUM_CH, leaves the bitmap unchanged.
- R10: Without an allocate request, alloc_gnt and alloc_none are both 0, and no bitmap bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request one free channel this cycle |
| alloc_gnt | output | 1 | A channel is granted this cycle |
| alloc_none | output | 1 | Request made but no channel free |
| alloc_idx | output | IDXW | Index of granted channel (valid with alloc_gnt) |
| rel_req | input | 1 | Release the channel named by rel_idx |
| rel_idx | input | IDXW | Channel index to release |
| busy_map | output | NUM_CH | One bit per channel, 1 = taken |

## Verification
The search is exercised in four ways. A fill from empty to full shows that level ranks above index, and that channels 16-19 come before 4-7. Scattered releases in levels 0, 2 and 3, followed by allocations, show the search order when free channels are sparse. A request with the pool full checks the none-free path. An allocate issued together with a release in the full state checks that the release is applied first. Two instances run side by side on the same stimulus, one with 32 channels and one with 20. Any difference between them in when none-free appears, or in how an out-of-range release is treated, points to a fault in the channel-count limit.

// File: rtl/challoc_pkg.sv
package challoc_pkg;
   localparam int MAX_CH     = 32;
   localparam int LEVEL_LSB  = 2;
   localparam int LEVEL_BITS = 2;
   localparam int NUM_LEVELS = 1 << LEVEL_BITS;

   // Priority level of a channel: index bits [LEVEL_LSB+LEVEL_BITS-1:LEVEL_LSB].
   function automatic int level_of(input int ch);
      return (ch >> LEVEL_LSB) & (NUM_LEVELS - 1);
   endfunction

   // Membership mask of one level among the first n channels.
   function automatic logic [MAX_CH-1:0] level_mask(input int n, input int lvl);
      logic [MAX_CH-1:0] m;
      m = '0;
      for (int i = 0; i < MAX_CH; i++)
         if (i < n && level_of(i) == lvl) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/challoc_lsb_pick.sv
// Lowest-set-bit encoder.
module challoc_lsb_pick #(
   parameter int W  = 8,
   parameter int IW = 3
) (
   input  logic [W-1:0]  cand,
   output logic          hit,
   output logic [IW-1:0] pos
);
   always_comb begin
      hit = 1'b0;
      pos = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (cand[i]) begin
            hit = 1'b1;
            pos = IW'(i);
         end
      end
   end
endmodule

// File: rtl/challoc_search.sv
// Level-ordered search: first non-empty level wins, lowest index inside it.
module challoc_search
   import challoc_pkg::*;
#(
   parameter int NUM_CH = 32,
   parameter int IDXW   = 5
) (
   input  logic [NUM_CH-1:0] avail,
   output logic              found,
   output logic [IDXW-1:0]   pick
);
   logic [NUM_LEVELS-1:0] lvl_hit;
   logic [IDXW-1:0]       lvl_pos [NUM_LEVELS];

   for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_level
      localparam logic [MAX_CH-1:0] FULL_MASK = level_mask(NUM_CH, lv);
      localparam logic [NUM_CH-1:0] MASK      = FULL_MASK[NUM_CH-1:0];
      logic [NUM_CH-1:0] cand;
      assign cand = avail & MASK;
      challoc_lsb_pick #(.W(NUM_CH), .IW(IDXW)) u_pick (
         .cand (cand),
         .hit  (lvl_hit[lv]),
         .pos  (lvl_pos[lv])
      );
   end

   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int lv = NUM_LEVELS - 1; lv >= 0; lv--) begin
         if (lvl_hit[lv]) begin
            found = 1'b1;
            pick  = lvl_pos[lv];
         end
      end
   end
endmodule

// File: rtl/challoc_busy_reg.sv
// Busy bitmap; release is applied before the set of a grant.
module challoc_busy_reg #(
   parameter int NUM_CH = 32,
   parameter int IDXW   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [IDXW-1:0]   set_idx,
   input  logic              clr_en,
   input  logic [IDXW-1:0]   clr_idx,
   output logic [NUM_CH-1:0] busy,
   output logic [NUM_CH-1:0] avail
);
   logic [NUM_CH-1:0] clr_mask, set_mask, after_clr;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
      assign clr_mask[i] = clr_en && (clr_idx == IDXW'(i));
      assign set_mask[i] = set_en && (set_idx == IDXW'(i));
   end

   assign after_clr = busy & ~clr_mask;
   assign avail     = ~after_clr;

   always_ff @(posedge clk) begin
      if (!rst_n) busy <= '0;
      else        busy <= after_clr | set_mask;
   end
endmodule

// File: rtl/prio_chan_alloc.sv
module prio_chan_alloc
   import challoc_pkg::*;
#(
   parameter int NUM_CH = 32,
   parameter int IDXW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_req,
   output logic              alloc_gnt,
   output logic              alloc_none,
   output logic [IDXW-1:0]   alloc_idx,
   input  logic              rel_req,
   input  logic [IDXW-1:0]   rel_idx,
   output logic [NUM_CH-1:0] busy_map
);
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_count
      $error("prio_chan_alloc: NUM_CH out of range");
   end
   if ((1 << IDXW) < NUM_CH) begin : g_bad_width
      $error("prio_chan_alloc: IDXW too narrow");
   end

   logic [NUM_CH-1:0] avail;
   logic              found;
   logic [IDXW-1:0]   pick;

   challoc_busy_reg #(.NUM_CH(NUM_CH), .IDXW(IDXW)) u_busy (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (alloc_gnt),
      .set_idx (pick),
      .clr_en  (rel_req),
      .clr_idx (rel_idx),
      .busy    (busy_map),
      .avail   (avail)
   );

   challoc_search #(.NUM_CH(NUM_CH), .IDXW(IDXW)) u_search (
      .avail (avail),
      .found (found),
      .pick  (pick)
   );

   assign alloc_gnt  = alloc_req && found;
   assign alloc_none = alloc_req && !found;
   assign alloc_idx  = pick;
endmodule

// File: rtl/prio_chan_alloc_chk.sv
module prio_chan_alloc_chk #(
   parameter int NUM_CH = 32,
   parameter int IDXW   = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              alloc_req,
   input logic              alloc_gnt,
   input logic              alloc_none,
   input logic [IDXW-1:0]   alloc_idx,
   input logic              rel_req,
   input logic [IDXW-1:0]   rel_idx,
   input logic [NUM_CH-1:0] busy_map
);
   localparam logic [IDXW:0] LIMIT = (IDXW + 1)'(NUM_CH);

   assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(alloc_gnt && alloc_none));

   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !alloc_req |-> (!alloc_gnt && !alloc_none));

   assert_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_gnt |-> ({1'b0, alloc_idx} < LIMIT));

   assert_marks_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_gnt |=> busy_map[$past(alloc_idx)]);

   assert_grant_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_gnt |-> (!busy_map[alloc_idx] || (rel_req && rel_idx == alloc_idx)));

   assert_full_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_none && !rel_req) |=> $stable(busy_map));

   assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_req && ({1'b0, rel_idx} < LIMIT) && !(alloc_gnt && alloc_idx == rel_idx))
      |=> !busy_map[$past(rel_idx)]);
endmodule

bind prio_chan_alloc prio_chan_alloc_chk #(.NUM_CH(NUM_CH), .IDXW(IDXW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .alloc_req  (alloc_req),
   .alloc_gnt  (alloc_gnt),
   .alloc_none (alloc_none),
   .alloc_idx  (alloc_idx),
   .rel_req    (rel_req),
   .rel_idx    (rel_idx),
   .busy_map   (busy_map)
);

// File: tb/prio_chan_alloc_tb.sv
`timescale 1ns/1ps
module prio_chan_alloc_tb;
   localparam int SMALL = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic alloc_req = 1'b0;
   logic rel_req = 1'b0;
   logic [4:0] rel_idx = '0;

   logic        gnt_a, none_a, gnt_b, none_b;
   logic [4:0]  idx_a, idx_b;
   logic [31:0] busy_a;
   logic [SMALL-1:0] busy_b;

   int vectors = 0;
   int miscompares = 0;
   logic [31:0] mdl_a = '0;
   logic [31:0] mdl_b = '0;

   always #2.5 clk = ~clk;

   prio_chan_alloc #(.NUM_CH(32)) u_dut (
      .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_gnt(gnt_a),
      .alloc_none(none_a), .alloc_idx(idx_a), .rel_req(rel_req),
      .rel_idx(rel_idx), .busy_map(busy_a));

   prio_chan_alloc #(.NUM_CH(SMALL)) u_dut20 (
      .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_gnt(gnt_b),
      .alloc_none(none_b), .alloc_idx(idx_b), .rel_req(rel_req),
      .rel_idx(rel_idx), .busy_map(busy_b));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Model search: level (i%16)>>2 first, then ascending index.
   function automatic int model_pick(input logic [31:0] b, input int n);
      for (int lv = 0; lv < 4; lv++)
         for (int i = 0; i < n; i++)
            if (((i % 16) / 4) == lv && !b[i]) return i;
      return -1;
   endfunction

   task automatic step(input logic a, input logic r, input int ri, input string tag);
      logic [31:0] pa, pb;
      int ea, eb;
      @(negedge clk);
      alloc_req = a; rel_req = r; rel_idx = 5'(ri);
      #1;
      pa = mdl_a; pb = mdl_b;
      if (r) begin
         pa[ri] = 1'b0;
         if (ri < SMALL) pb[ri] = 1'b0;
      end
      ea = model_pick(pa, 32);
      eb = model_pick(pb, SMALL);
      chk({tag, " gnt32"},  {31'b0, gnt_a},  {31'b0, a && ea >= 0});
      chk({tag, " none32"}, {31'b0, none_a}, {31'b0, a && ea < 0});
      if (a && ea >= 0) chk({tag, " idx32"}, {27'b0, idx_a}, ea);
      chk({tag, " gnt20"},  {31'b0, gnt_b},  {31'b0, a && eb >= 0});
      chk({tag, " none20"}, {31'b0, none_b}, {31'b0, a && eb < 0});
      if (a && eb >= 0) chk({tag, " idx20"}, {27'b0, idx_b}, eb);
      if (a && ea >= 0) pa[ea] = 1'b1;
      if (a && eb >= 0) pb[eb] = 1'b1;
      mdl_a = pa; mdl_b = pb;
      @(posedge clk);
      #1;
      chk({tag, " R4 busy32"}, busy_a, mdl_a);
      chk({tag, " R4 busy20"}, {12'b0, busy_b}, mdl_b);
   endtask

   task automatic t_reset_R1();
      repeat (3) @(posedge clk);
      #1;
      chk("R1 busy32 in reset", busy_a, 32'h0);
      chk("R1 busy20 in reset", {12'b0, busy_b}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 busy32 after reset", busy_a, 32'h0);
      chk("R1 gnt idle", {30'b0, gnt_a, none_a}, 32'h0);
   endtask

   task automatic t_idle_R10();
      step(1'b0, 1'b0, 0, "R10");
   endtask

   task automatic t_fill_R3();
      for (int k = 0; k < 32; k++) step(1'b1, 1'b0, 0, "R3/R2/R7");
      chk("R3 full map", busy_a, 32'hFFFF_FFFF);
   endtask

   task automatic t_full_R5();
      step(1'b1, 1'b0, 0, "R5");
      step(1'b1, 1'b0, 0, "R5");
   endtask

   task automatic t_same_cycle_R8();
      step(1'b1, 1'b1, 9, "R8");
   endtask

   task automatic t_release_R6();
      step(1'b0, 1'b1, 13, "R6");
      step(1'b0, 1'b1, 26, "R6/R9");
      step(1'b0, 1'b1, 17, "R6");
      step(1'b1, 1'b0, 0, "R2");
      step(1'b1, 1'b0, 0, "R2");
      step(1'b1, 1'b0, 0, "R2");
   endtask

   task automatic t_noop_release_R9();
      step(1'b0, 1'b1, 30, "R9");
      step(1'b0, 1'b1, 30, "R9");
      step(1'b0, 1'b1, 30, "R9");
      step(1'b1, 1'b0, 0, "R9");
      step(1'b0, 1'b0, 0, "R10");
   endtask

   initial begin
      t_reset_R1();
      t_idle_R10();
      t_fill_R3();
      t_full_R5();
      t_same_cycle_R8();
      t_release_R6();
      t_noop_release_R9();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(200000 * 5);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule